// File: doc/BRIEF.md
# Time-Shared Quad-Port Memory

This block is a memory with four ports, all in the slow port clock domain: two write ports (A and B) and two read ports (A and B). Each slow cycle, each write port can store one word and each read port returns one word. Inside, there are two mirrored true dual-port RAM copies. They run on a core clock that is phase-locked to the port clock at 1.5 times its rate, so two port cycles span exactly three core cycles.

Slow cycles are grouped in pairs. The first slow edge after reset release opens the first slot of a pair. Port requests are captured into one of two slot registers, chosen by a slot pointer that alternates on every port edge.

A core-domain phase sequencer runs through three named states:
- `PH_WR0`: both copies write the two words of slot 0.
- `PH_WR1`: both copies write the two words of slot 1.
- `PH_RD`: all four RAM ports read. Copy 0 serves the two slot-0 reads and copy 1 serves the two slot-1 reads.

The transitions are fixed and unconditional: `PH_WR0 -> PH_WR1`, `PH_WR1 -> PH_RD`, `PH_RD -> PH_WR0`. Reset parks the sequencer in `PH_RD`. A realignment stage then returns the read words to the port clock, one slot per edge.

Reset must be released between the second and the third core edge after an edge where both clocks rise together. This places the next port edge and core edge on a shared edge.

Top module: `qp_timeshare_mem`

## Requirements
- R1: While `rst` is high, `ra_data` and `rb_data` are zero.
- R2: A write port with its enable high stores its data word at its address in the slow cycle where it is presented.
- R3: A write port with its enable low leaves the memory unchanged.
- R4: When both write ports have their enables high and hold the same address in one slow cycle, port B's word is stored.
- R5: A read in either slot of a pair returns the contents after both slots' writes of that same pair. Writes of the own slow cycle are therefore visible (write-first). A second-slot write also overrides a first-slot write to the same address.
- R6: A read never sees a write presented in a later pair.
- R7: The result of a read presented before port edge k appears on the read data outputs after port edge k+3. It is held until port edge k+4.
- R8: The two read ports are independent. Both ports may name the same address and both then return the same word.
- R9: The core sequencer steps `PH_WR0 -> PH_WR1 -> PH_RD -> PH_WR0`, and reset leaves it in `PH_RD`. Write enables are never raised in `PH_RD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_port | input | 1 | Port clock (slow) |
| clk_core | input | 1 | Core clock, 1.5x port clock, phase-locked |
| rst | input | 1 | Synchronous reset, high active, seen by both clocks |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | ADDR_W | Write port A address |
| wa_data | input | DATA_W | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | ADDR_W | Write port B address |
| wb_data | input | DATA_W | Write port B data |
| ra_addr | input | ADDR_W | Read port A address |
| rb_addr | input | ADDR_W | Read port B address |
| ra_data | output | DATA_W | Read port A data, three port cycles after the request |
| rb_data | output | DATA_W | Read port B data, three port cycles after the request |

## Verification
The bench attacks the following cases:

- **Pair ordering.** First-slot reads must already show the second slot's writes, while an earlier pair's read must not show a later pair's write. A sequencer that read before writing, or that drifted by one phase, returns stale or future words.
- **Same-address collisions.** It drives both write ports at one address, and a disabled port with live address and data. A wrong port priority or an ignored enable leaves the wrong word in place.
- **Latency.** Every slow cycle carries a read whose result is checked on exactly its due edge. A realignment stage that swapped slots or slipped by one edge fails on every pair.

// File: rtl/qp_pkg.sv
`timescale 1ns/1ps
package qp_pkg;

    // number of write ports, read ports, request slots per pair, RAM copies
    localparam int NPORT = 2;
    localparam int NSLOT = 2;
    localparam int NCOPY = 2;

    // core-clock phase within a group of three core cycles
    typedef enum logic [1:0] {
        PH_WR0 = 2'd0,
        PH_WR1 = 2'd1,
        PH_RD  = 2'd2
    } phase_e;

endpackage

// File: rtl/qp_capture.sv
`timescale 1ns/1ps
// Port-clock capture: each port edge stores the four requests into the slot
// named by the slot pointer, which alternates every edge.
module qp_capture #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic clk_port,
    input  logic rst,
    input  logic wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic slot_o,
    output logic [qp_pkg::NSLOT-1:0][qp_pkg::NPORT-1:0] wen_o,
    output logic [qp_pkg::NSLOT-1:0][qp_pkg::NPORT-1:0][AW-1:0] waddr_o,
    output logic [qp_pkg::NSLOT-1:0][qp_pkg::NPORT-1:0][DW-1:0] wdata_o,
    output logic [qp_pkg::NSLOT-1:0][qp_pkg::NPORT-1:0][AW-1:0] raddr_o
);
    import qp_pkg::*;

    logic [NPORT-1:0] in_wen;
    logic [NPORT-1:0][AW-1:0] in_waddr;
    logic [NPORT-1:0][DW-1:0] in_wdata;
    logic [NPORT-1:0][AW-1:0] in_raddr;

    always_comb begin
        in_wen = {wb_en, wa_en};
        in_waddr = {wb_addr, wa_addr};
        in_wdata = {wb_data, wa_data};
        in_raddr = {rb_addr, ra_addr};
    end

    always_ff @(posedge clk_port) begin
        if (rst) begin
            slot_o <= 1'b0;
            wen_o <= '0;
            waddr_o <= '0;
            wdata_o <= '0;
            raddr_o <= '0;
        end else begin
            slot_o <= ~slot_o;
            wen_o[slot_o] <= in_wen;
            waddr_o[slot_o] <= in_waddr;
            wdata_o[slot_o] <= in_wdata;
            raddr_o[slot_o] <= in_raddr;
        end
    end

endmodule

// File: rtl/qp_sequencer.sv
`timescale 1ns/1ps
// Core-clock phase sequencer: steers the captured slots onto the four RAM
// ports. Both write phases drive both copies alike; the read phase uses all four.
module qp_sequencer #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic clk_core,
    input  logic rst,
    input  logic [qp_pkg::NSLOT-1:0][qp_pkg::NPORT-1:0] wen_i,
    input  logic [qp_pkg::NSLOT-1:0][qp_pkg::NPORT-1:0][AW-1:0] waddr_i,
    input  logic [qp_pkg::NSLOT-1:0][qp_pkg::NPORT-1:0][DW-1:0] wdata_i,
    input  logic [qp_pkg::NSLOT-1:0][qp_pkg::NPORT-1:0][AW-1:0] raddr_i,
    output logic [qp_pkg::NCOPY-1:0][qp_pkg::NPORT-1:0] ram_we,
    output logic [qp_pkg::NCOPY-1:0][qp_pkg::NPORT-1:0] ram_re,
    output logic [qp_pkg::NCOPY-1:0][qp_pkg::NPORT-1:0][AW-1:0] ram_addr,
    output logic [qp_pkg::NCOPY-1:0][qp_pkg::NPORT-1:0][DW-1:0] ram_wdata
);
    import qp_pkg::*;

    phase_e state_q;
    phase_e state_d;

    // slot-0 read addresses, taken while slot 0 is stable so that the
    // shared edge of the read phase never samples a slot being refilled
    logic [NPORT-1:0][AW-1:0] rd_hold_q;

    always_comb begin
        unique case (state_q)
            PH_WR0:  state_d = PH_WR1;
            PH_WR1:  state_d = PH_RD;
            PH_RD:   state_d = PH_WR0;
            default: state_d = PH_RD;
        endcase
    end

    always_ff @(posedge clk_core) begin
        if (rst) begin
            state_q <= PH_RD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_core) begin
        if (rst) begin
            rd_hold_q <= '0;
        end else if (state_q == PH_WR0) begin
            rd_hold_q <= raddr_i[0];
        end
    end

    always_comb begin
        ram_we = '0;
        ram_re = '0;
        ram_addr = '0;
        ram_wdata = '0;
        unique case (state_q)
            PH_WR0: begin
                for (int c = 0; c < NCOPY; c++) begin
                    for (int p = 0; p < NPORT; p++) begin
                        ram_we[c][p] = wen_i[0][p];
                        ram_addr[c][p] = waddr_i[0][p];
                        ram_wdata[c][p] = wdata_i[0][p];
                    end
                end
            end
            PH_WR1: begin
                for (int c = 0; c < NCOPY; c++) begin
                    for (int p = 0; p < NPORT; p++) begin
                        ram_we[c][p] = wen_i[1][p];
                        ram_addr[c][p] = waddr_i[1][p];
                        ram_wdata[c][p] = wdata_i[1][p];
                    end
                end
            end
            PH_RD: begin
                for (int c = 0; c < NCOPY; c++) begin
                    for (int p = 0; p < NPORT; p++) begin
                        ram_re[c][p] = 1'b1;
                        ram_addr[c][p] = (c == 0) ? rd_hold_q[p] : raddr_i[c][p];
                    end
                end
            end
            default: begin
            end
        endcase
    end

    // R9: fixed three-phase order
    a_r9_wr0_then_wr1: assert property (@(posedge clk_core) disable iff (rst)
        (state_q == PH_WR0) |=> (state_q == PH_WR1));
    a_r9_wr1_then_rd: assert property (@(posedge clk_core) disable iff (rst)
        (state_q == PH_WR1) |=> (state_q == PH_RD));
    a_r9_rd_then_wr0: assert property (@(posedge clk_core) disable iff (rst)
        (state_q == PH_RD) |=> (state_q == PH_WR0));

endmodule

// File: rtl/qp_dpram.sv
`timescale 1ns/1ps
// One true dual-port RAM copy: two writes or two reads per core edge,
// registered read data that only moves on a read enable.
module qp_dpram #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic we_a,
    input  logic re_a,
    input  logic [AW-1:0] addr_a,
    input  logic [DW-1:0] wdata_a,
    output logic [DW-1:0] rdata_a,
    input  logic we_b,
    input  logic re_b,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] wdata_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];
    logic clash;

    // same address on both ports: port B takes the word
    always_comb clash = we_a && we_b && (addr_a == addr_b);

    always_ff @(posedge clk) begin
        if (we_a && !clash) begin
            mem[addr_a] <= wdata_a;
        end
        if (we_b) begin
            mem[addr_b] <= wdata_b;
        end
        if (re_a) begin
            rdata_a <= mem[addr_a];
        end
        if (re_b) begin
            rdata_b <= mem[addr_b];
        end
    end

    // R2: an enabled port A write lands unless port B claims the address
    a_r2_port_a_lands: assert property (@(posedge clk) disable iff (rst)
        (we_a && !(we_b && addr_a == addr_b)) |=> (mem[$past(addr_a)] == $past(wdata_a)));
    // R4: port B always lands
    a_r4_port_b_wins: assert property (@(posedge clk) disable iff (rst)
        we_b |=> (mem[$past(addr_b)] == $past(wdata_b)));
    // R9: the sequencer never mixes reads and writes on one edge
    a_r9_no_write_when_read: assert property (@(posedge clk) disable iff (rst)
        (re_a || re_b) |-> !(we_a || we_b));

endmodule

// File: rtl/qp_realign.sv
`timescale 1ns/1ps
// Return path to the port clock: the edge that fills slot 1 presents the
// slot-0 results and parks the slot-1 results; the next edge presents those.
module qp_realign #(
    parameter int DW = 16
) (
    input  logic clk_port,
    input  logic rst,
    input  logic slot_i,
    input  logic [qp_pkg::NCOPY-1:0][qp_pkg::NPORT-1:0][DW-1:0] rdata_i,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data
);
    import qp_pkg::*;

    logic [NPORT-1:0][DW-1:0] park_q;

    always_ff @(posedge clk_port) begin
        if (rst) begin
            ra_data <= '0;
            rb_data <= '0;
            park_q <= '0;
        end else if (slot_i) begin
            ra_data <= rdata_i[0][0];
            rb_data <= rdata_i[0][1];
            park_q <= rdata_i[1];
        end else begin
            ra_data <= park_q[0];
            rb_data <= park_q[1];
        end
    end

endmodule

// File: rtl/qp_timeshare_mem.sv
`timescale 1ns/1ps
module qp_timeshare_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic clk_port,
    input  logic clk_core,
    input  logic rst,
    input  logic wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [ADDR_W-1:0] ra_addr,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data
);
    import qp_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic slot;
    logic [NSLOT-1:0][NPORT-1:0] cap_wen;
    logic [NSLOT-1:0][NPORT-1:0][ADDR_W-1:0] cap_waddr;
    logic [NSLOT-1:0][NPORT-1:0][DATA_W-1:0] cap_wdata;
    logic [NSLOT-1:0][NPORT-1:0][ADDR_W-1:0] cap_raddr;

    logic [NCOPY-1:0][NPORT-1:0] ram_we;
    logic [NCOPY-1:0][NPORT-1:0] ram_re;
    logic [NCOPY-1:0][NPORT-1:0][ADDR_W-1:0] ram_addr;
    logic [NCOPY-1:0][NPORT-1:0][DATA_W-1:0] ram_wdata;
    logic [NCOPY-1:0][NPORT-1:0][DATA_W-1:0] ram_rdata;

    qp_capture #(.AW(ADDR_W), .DW(DATA_W)) u_capture (
        .clk_port(clk_port),
        .rst(rst),
        .wa_en(wa_en),
        .wa_addr(wa_addr),
        .wa_data(wa_data),
        .wb_en(wb_en),
        .wb_addr(wb_addr),
        .wb_data(wb_data),
        .ra_addr(ra_addr),
        .rb_addr(rb_addr),
        .slot_o(slot),
        .wen_o(cap_wen),
        .waddr_o(cap_waddr),
        .wdata_o(cap_wdata),
        .raddr_o(cap_raddr)
    );

    qp_sequencer #(.AW(ADDR_W), .DW(DATA_W)) u_seq (
        .clk_core(clk_core),
        .rst(rst),
        .wen_i(cap_wen),
        .waddr_i(cap_waddr),
        .wdata_i(cap_wdata),
        .raddr_i(cap_raddr),
        .ram_we(ram_we),
        .ram_re(ram_re),
        .ram_addr(ram_addr),
        .ram_wdata(ram_wdata)
    );

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        qp_dpram #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_ram (
            .clk(clk_core),
            .rst(rst),
            .we_a(ram_we[c][0]),
            .re_a(ram_re[c][0]),
            .addr_a(ram_addr[c][0]),
            .wdata_a(ram_wdata[c][0]),
            .rdata_a(ram_rdata[c][0]),
            .we_b(ram_we[c][1]),
            .re_b(ram_re[c][1]),
            .addr_b(ram_addr[c][1]),
            .wdata_b(ram_wdata[c][1]),
            .rdata_b(ram_rdata[c][1])
        );
    end

    qp_realign #(.DW(DATA_W)) u_realign (
        .clk_port(clk_port),
        .rst(rst),
        .slot_i(slot),
        .rdata_i(ram_rdata),
        .ra_data(ra_data),
        .rb_data(rb_data)
    );

endmodule

// File: tb/qp_timeshare_mem_test.sv
`timescale 1ns/1ps
module qp_timeshare_mem_test;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic clk_port, clk_core, rst;
    logic wa_en, wb_en;
    logic [AW-1:0] wa_addr, wb_addr, ra_addr, rb_addr;
    logic [DW-1:0] wa_data, wb_data, ra_data, rb_data;

    typedef struct {
        logic wa_en;
        logic [AW-1:0] wa_addr;
        logic [DW-1:0] wa_data;
        logic wb_en;
        logic [AW-1:0] wb_addr;
        logic [DW-1:0] wb_data;
        logic [AW-1:0] ra_addr;
        logic [AW-1:0] rb_addr;
    } req_t;

    typedef struct {
        int due;
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        string tag;
    } exp_t;

    exp_t sb[$];
    logic [DW-1:0] model [DEPTH];
    int n_checks = 0;
    int n_fail = 0;
    int edge_cnt = 0;
    int drv_cyc = 0;
    bit started = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5679;
    event ev_align;

    qp_timeshare_mem #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk_port(clk_port), .clk_core(clk_core), .rst(rst),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .ra_addr(ra_addr), .rb_addr(rb_addr),
        .ra_data(ra_data), .rb_data(rb_data)
    );

    // core 100 MHz, port 66.7 MHz, rising together every 30 ns
    initial begin
        clk_port = 0;
        clk_core = 0;
        forever begin
            for (int n = 0; n < 12; n++) begin
                clk_core = ((n % 4) < 2);
                clk_port = ((n % 6) < 3);
                if (n == 0) -> ev_align;
                #2.5;
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic req_t mk(input logic a_en, input int a_ad, input logic [DW-1:0] a_d,
                                input logic b_en, input int b_ad, input logic [DW-1:0] b_d,
                                input int r_a, input int r_b);
        req_t r;
        r.wa_en = a_en; r.wa_addr = AW'(a_ad); r.wa_data = a_d;
        r.wb_en = b_en; r.wb_addr = AW'(b_ad); r.wb_data = b_d;
        r.ra_addr = AW'(r_a); r.rb_addr = AW'(r_b);
        return r;
    endfunction

    task automatic drive(input req_t r);
        wa_en = r.wa_en; wa_addr = r.wa_addr; wa_data = r.wa_data;
        wb_en = r.wb_en; wb_addr = r.wb_addr; wb_data = r.wb_data;
        ra_addr = r.ra_addr; rb_addr = r.rb_addr;
    endtask

    task automatic apply_writes(input req_t r);
        if (r.wa_en) model[r.wa_addr] = r.wa_data;
        if (r.wb_en) model[r.wb_addr] = r.wb_data;
    endtask

    // driver: one pair of port cycles, then the scoreboard learns both reads
    task automatic run_pair(input req_t ev, input req_t od, input string tag);
        exp_t x;
        drive(ev);
        @(posedge clk_port); @(negedge clk_port);
        drive(od);
        @(posedge clk_port); @(negedge clk_port);
        apply_writes(ev);
        apply_writes(od);
        x.tag = tag;
        x.due = drv_cyc + 3; x.ea = model[ev.ra_addr]; x.eb = model[ev.rb_addr];
        sb.push_back(x);
        x.due = drv_cyc + 4; x.ea = model[od.ra_addr]; x.eb = model[od.rb_addr];
        sb.push_back(x);
        drv_cyc += 2;
    endtask

    task automatic rnd_req(output req_t r);
        for (int i = 0; i < 4; i++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            case (i)
                0: begin r.wa_en = seed[0]; r.wa_addr = seed[8:3]; r.wa_data = seed[31:16]; end
                1: begin r.wb_en = seed[1]; r.wb_addr = seed[9:4]; r.wb_data = seed[31:16]; end
                2: begin r.ra_addr = seed[7:2]; r.rb_addr = seed[15:10]; end
                default: if (seed[20]) r.wb_addr = r.wa_addr;
            endcase
        end
    endtask

    // monitor: each port edge after release owes exactly one scoreboard item
    initial begin
        int idx;
        exp_t x;
        forever begin
            @(posedge clk_port);
            if (started && !done) begin
                idx = edge_cnt;
                edge_cnt++;
                @(negedge clk_port);
                while (sb.size() > 0 && sb[0].due < idx) begin
                    x = sb.pop_front();
                    n_checks++;
                    n_fail++;
                    $display("FAIL R7 result missed: got edge %0d expected edge %0d", idx, x.due);
                end
                if (sb.size() > 0 && sb[0].due == idx) begin
                    x = sb.pop_front();
                    chk(x.tag, "read port A", ra_data, x.ea);
                    chk(x.tag, "read port B", rb_data, x.eb);
                end
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        req_t idle, a, b;
        idle = mk(0, 0, '0, 0, 0, '0, 0, 0);
        rst = 1;
        drive(idle);
        repeat (4) @(posedge clk_port);
        @(negedge clk_port);
        chk("R1", "reset read port A", ra_data, '0);
        chk("R1", "reset read port B", rb_data, '0);

        @(ev_align);
        #25;
        rst = 0;
        started = 1;

        // R2 and R5: fill every address, reading each in its own pair
        for (int p = 0; p < DEPTH / 4; p++) begin
            a = mk(1, 4*p,   DW'(4*p*37 + 5),   1, 4*p+1, DW'((4*p+1)*37 + 5), 4*p,   4*p+1);
            b = mk(1, 4*p+2, DW'((4*p+2)*37 + 5), 1, 4*p+3, DW'((4*p+3)*37 + 5), 4*p+2, 4*p+3);
            run_pair(a, b, "R2");
        end

        // R3: disabled ports carry live address and data
        run_pair(mk(0, 5, 16'hBEEF, 0, 6, 16'hDEAD, 5, 6), mk(0, 6, 16'h0BAD, 0, 5, 16'hF00D, 6, 5), "R3");
        // R4: both write ports on one address, B must stay
        run_pair(mk(1, 7, 16'h1234, 1, 7, 16'h5678, 7, 7), mk(1, 8, 16'h0001, 1, 8, 16'h0002, 8, 7), "R4");
        // R5: first slot reads see second slot writes, later write overrides
        run_pair(mk(1, 9, 16'hAAAA, 0, 0, 16'h0, 9, 10), mk(1, 10, 16'hCCCC, 1, 9, 16'hBBBB, 9, 10), "R5");
        // R6: a read of address 11 must not see the next pair's write
        run_pair(mk(0, 0, 16'h0, 0, 0, 16'h0, 11, 12), idle, "R6");
        run_pair(mk(1, 11, 16'h7777, 0, 0, 16'h0, 11, 12), mk(0, 0, 16'h0, 1, 12, 16'h6666, 12, 11), "R6");
        // R8: both read ports on one address
        run_pair(mk(0, 0, 16'h0, 0, 0, 16'h0, 20, 20), mk(0, 0, 16'h0, 0, 0, 16'h0, 7, 7), "R8");
        // R7: distinct words each cycle expose a slipped or swapped slot
        run_pair(mk(0, 0, 16'h0, 0, 0, 16'h0, 30, 31), mk(0, 0, 16'h0, 0, 0, 16'h0, 32, 33), "R7");
        run_pair(mk(0, 0, 16'h0, 0, 0, 16'h0, 34, 35), mk(0, 0, 16'h0, 0, 0, 16'h0, 36, 37), "R7");

        for (int p = 0; p < 40; p++) begin
            rnd_req(a);
            rnd_req(b);
            run_pair(a, b, "R2");
        end

        drive(idle);
        repeat (6) @(posedge clk_port);
        @(negedge clk_port);
        if (sb.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 results pending: got %0d expected 0", sb.size());
        end
        finish_run();
    end

endmodule